// File: doc/BRIEF.md
# Descending Word Stack Pointer Unit

This block owns the 16-bit stack pointer of a small processor whose stack sits in word-organised RAM and grows toward lower addresses. Each cycle it takes one command: push a data word, pop a word, save the program counter on a call or on interrupt entry, or restore it on a return or a return from interrupt. For each command it drives the address, write enable, read enable and write data of a synchronous single-port RAM. On the cycle after a pop it hands the word the RAM returns to the consumer, and on the cycle after a return it also tells the program counter to load that word.

The pointer is always even. Its lowest bit is not stored. A push moves the pointer down one word and then writes at the new address. A pop reads at the current address and then moves the pointer up one word. The empty-stack value and a floor address that guards the data area below the stack are parameters. A pop from an empty stack is refused and reported. A push that crosses the floor is carried out and reported. Software can also overwrite the pointer through a dedicated load port.

Top module: `stack_ptr_unit`

## Requirements
- R1: The pointer value on `sp_o` always has bit 0 at zero. A value written through `sp_ld_en`/`sp_ld_val` appears on `sp_o` one cycle later with bit 0 cleared and its upper 15 bits unchanged.
- R2: `cmd_op` = 1 (push) drives `mem_we`=1, `mem_addr`=`sp_o`-2 and `mem_wdata`=`push_data` in the same cycle. `sp_o` falls by 2 at the next clock edge.
- R3: `cmd_op` = 2 (pop) on a non-empty stack drives `mem_re`=1 and `mem_addr`=`sp_o` in the same cycle. In the next cycle `pop_valid` is 1 and `pop_word` holds the word stored at that address, and `sp_o` has risen by 2.
- R4: `cmd_op` = 3 (call) and `cmd_op` = 4 (interrupt entry) behave like a push, except that the word written is `pc_in`.
- R5: `cmd_op` = 5 (return) and `cmd_op` = 6 (return from interrupt) behave like a pop, and in the following cycle they also raise `pc_load` together with `pop_valid`.
- R6: A pop-class command (2, 5 or 6) issued while `sp_o` is at or above the empty value `TOP_ADDR` does not access memory and leaves `sp_o` unchanged. In the next cycle it raises `underflow` for one cycle, with `pop_valid` and `pc_load` at 0.
- R7: A push-class command (1, 3 or 4) issued while `sp_o` - 2 is below `FLOOR_ADDR` still writes and still decrements. In the next cycle it raises `overflow` for one cycle.
- R8: After reset `sp_o` equals `TOP_ADDR`, and `pop_valid`, `pc_load`, `overflow` and `underflow` are 0.
- R9: While `sp_ld_en` is 1, any command in the same cycle is dropped. No memory access takes place, no flag is raised, and only the load changes `sp_o`.
- R10: Commands can be issued on consecutive cycles with no idle cycle between them. Each command sees the pointer left by the previous one. `cmd_op` = 0 and 7 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | Command: 0 none, 1 push, 2 pop, 3 call, 4 interrupt entry, 5 return, 6 return from interrupt, 7 none |
| push_data | input | 16 | Word written by a push |
| pc_in | input | 16 | Program counter saved by a call or interrupt entry |
| sp_ld_en | input | 1 | Load the pointer from `sp_ld_val` |
| sp_ld_val | input | 16 | Value for a direct pointer load |
| mem_addr | output | 16 | Byte address of the stack access |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe |
| mem_wdata | output | 16 | Word written to RAM |
| mem_rdata | input | 16 | RAM read data, one cycle after `mem_re` |
| pop_valid | output | 1 | `pop_word` is valid this cycle |
| pop_word | output | 16 | Popped word, also the value for the program counter |
| pc_load | output | 1 | Load the program counter from `pop_word` |
| sp_o | output | 16 | Current stack pointer |
| overflow | output | 1 | One-cycle pulse: the last push crossed the floor |
| underflow | output | 1 | One-cycle pulse: the last pop found the stack empty |

## Verification
The assertions assume that the RAM returns the addressed word on `mem_rdata` in the cycle after `mem_re` and that `cmd_op` is never unknown while the unit is out of reset. The bench keeps to this by attaching a one-cycle synchronous RAM model and by changing inputs only on the falling clock edge. Its reference model follows the pointer and a shadow copy of the stack in integers and an associative array. It compares every memory strobe in the same cycle and every result pulse one cycle later. The stimulus includes an empty-stack pop, a fill past the floor, loads with odd values and loads that collide with commands, so each guarded case occurs.

// File: rtl/spu_pkg.sv
`timescale 1ns/1ps
package spu_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_CALL = 3'd3,
    OP_IRQ  = 3'd4,
    OP_RET  = 3'd5,
    OP_RETI = 3'd6,
    OP_RSV  = 3'd7
  } spu_op_e;

  function automatic logic op_is_push(spu_op_e op);
    return (op == OP_PUSH) || (op == OP_CALL) || (op == OP_IRQ);
  endfunction

  function automatic logic op_is_pop(spu_op_e op);
    return (op == OP_POP) || (op == OP_RET) || (op == OP_RETI);
  endfunction

  function automatic logic op_is_return(spu_op_e op);
    return (op == OP_RET) || (op == OP_RETI);
  endfunction
endpackage

// File: rtl/spu_guard.sv
`timescale 1ns/1ps
module spu_guard #(
  parameter int unsigned     DW         = 16,
  parameter logic [DW-1:0]   TOP_ADDR   = 16'h0280,
  parameter logic [DW-1:0]   FLOOR_ADDR = 16'h0260
) (
  input  logic [DW-1:0] sp_i,
  output logic          below_floor_o,
  output logic          empty_o
);
  localparam logic [DW:0]   FLOOR_TRIP = {1'b0, FLOOR_ADDR} + (DW+1)'(2);
  localparam logic [DW-1:0] TOP_EVEN   = {TOP_ADDR[DW-1:1], 1'b0};

  // Compare one bit wider so that a pointer near zero cannot wrap.
  always_comb begin
    below_floor_o = ({1'b0, sp_i} < FLOOR_TRIP);
    empty_o       = (sp_i >= TOP_EVEN);
  end
endmodule

// File: rtl/spu_ptr_reg.sv
`timescale 1ns/1ps
module spu_ptr_reg #(
  parameter int unsigned   DW       = 16,
  parameter logic [DW-1:0] TOP_ADDR = 16'h0280
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en_i,
  input  logic [DW-1:0] load_val_i,
  input  logic          dec_i,
  input  logic          inc_i,
  output logic [DW-1:0] sp_o
);
  localparam int unsigned WW = DW - 1;

  logic [WW-1:0] word_q, word_d;
  logic          word_en;

  // Only the word index is stored; bit 0 is a constant zero.
  always_comb begin
    word_en = load_en_i | dec_i | inc_i;
    word_d  = word_q;
    if (load_en_i)  word_d = load_val_i[DW-1:1];
    else if (dec_i) word_d = word_q - WW'(1);
    else if (inc_i) word_d = word_q + WW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= TOP_ADDR[DW-1:1];
    else if (word_en) word_q <= word_d;
  end

  assign sp_o = {word_q, 1'b0};

  a_r1_load_even: assert property (@(posedge clk) disable iff (!rst_n)
    load_en_i |=> sp_o == {$past(load_val_i[DW-1:1]), 1'b0});
  a_r2_push_down: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_en_i) |=> sp_o == $past(sp_o) - DW'(2));
  a_r3_pop_up: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !dec_i && !load_en_i) |=> sp_o == $past(sp_o) + DW'(2));
endmodule

// File: rtl/spu_resp.sv
`timescale 1ns/1ps
module spu_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic pop_go_i,
  input  logic ret_go_i,
  input  logic ovf_ev_i,
  input  logic unf_ev_i,
  output logic pop_valid_o,
  output logic pc_load_o,
  output logic overflow_o,
  output logic underflow_o
);
  logic [3:0] ev_q, ev_d;

  always_comb ev_d = {unf_ev_i, ovf_ev_i, ret_go_i, pop_go_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= ev_d;
  end

  assign pop_valid_o = ev_q[0];
  assign pc_load_o   = ev_q[1];
  assign overflow_o  = ev_q[2];
  assign underflow_o = ev_q[3];

  a_r5_pc_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |-> pop_valid_o);
  a_r6_no_data_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> !pop_valid_o && !pc_load_o);
endmodule

// File: rtl/stack_ptr_unit.sv
`timescale 1ns/1ps
module stack_ptr_unit
  import spu_pkg::*;
#(
  parameter int unsigned   DW         = 16,
  parameter logic [DW-1:0] TOP_ADDR   = 16'h0280,
  parameter logic [DW-1:0] FLOOR_ADDR = 16'h0260
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cmd_op,
  input  logic [DW-1:0] push_data,
  input  logic [DW-1:0] pc_in,
  input  logic          sp_ld_en,
  input  logic [DW-1:0] sp_ld_val,
  output logic [DW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          pop_valid,
  output logic [DW-1:0] pop_word,
  output logic          pc_load,
  output logic [DW-1:0] sp_o,
  output logic          overflow,
  output logic          underflow
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  spu_op_e op;
  logic    push_req, pop_req, ret_req;
  logic    below_floor, empty;
  logic    pop_go, ret_go, ovf_ev, unf_ev;

  always_comb begin
    op       = spu_op_e'(cmd_op);
    push_req = !sp_ld_en && op_is_push(op);
    pop_req  = !sp_ld_en && op_is_pop(op);
    ret_req  = !sp_ld_en && op_is_return(op);
    pop_go   = pop_req && !empty;
    ret_go   = ret_req && !empty;
    unf_ev   = pop_req && empty;
    ovf_ev   = push_req && below_floor;
  end

  spu_guard #(.DW(DW), .TOP_ADDR(TOP_ADDR), .FLOOR_ADDR(FLOOR_ADDR)) guard_i (
    .sp_i(sp_o), .below_floor_o(below_floor), .empty_o(empty));

  spu_ptr_reg #(.DW(DW), .TOP_ADDR(TOP_ADDR)) ptr_i (
    .clk(clk), .rst_n(rst_int_n), .load_en_i(sp_ld_en), .load_val_i(sp_ld_val),
    .dec_i(push_req), .inc_i(pop_go), .sp_o(sp_o));

  spu_resp resp_i (
    .clk(clk), .rst_n(rst_int_n), .pop_go_i(pop_go), .ret_go_i(ret_go),
    .ovf_ev_i(ovf_ev), .unf_ev_i(unf_ev), .pop_valid_o(pop_valid),
    .pc_load_o(pc_load), .overflow_o(overflow), .underflow_o(underflow));

  // Memory side: pre-decrement address for writes, current pointer for reads.
  always_comb begin
    mem_we    = push_req;
    mem_re    = pop_go;
    mem_addr  = push_req ? (sp_o - DW'(2)) : sp_o;
    mem_wdata = (op == OP_PUSH) ? push_data : pc_in;
  end

  assign pop_word = mem_rdata;

  a_r9_load_blocks_mem: assert property (@(posedge clk) disable iff (!rst_int_n)
    sp_ld_en |-> !mem_we && !mem_re);
  a_r3_read_then_valid: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_re |=> pop_valid);
  a_r7_overflow_writes: assert property (@(posedge clk) disable iff (!rst_int_n)
    overflow |-> $past(mem_we));
  a_r6_underflow_holds: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_is_pop(spu_op_e'(cmd_op)) && !sp_ld_en && sp_o == {TOP_ADDR[DW-1:1], 1'b0})
      |=> underflow && $stable(sp_o));
  a_r1_even_addr: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_we || mem_re) |-> mem_addr[0] == 1'b0);
endmodule

// File: tb/stack_ptr_unit_tb_top.sv
`timescale 1ns/1ps
module stack_ptr_unit_tb_top;
  localparam int TOP   = 'h0280;
  localparam int FLOOR = 'h0260;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cmd_op;
  logic [15:0] push_data, pc_in, sp_ld_val, mem_addr, mem_wdata, mem_rdata, pop_word, sp_o;
  logic        sp_ld_en, mem_we, mem_re, pop_valid, pc_load, overflow, underflow;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  stack_ptr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .push_data(push_data), .pc_in(pc_in),
    .sp_ld_en(sp_ld_en), .sp_ld_val(sp_ld_val), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pop_valid(pop_valid),
    .pop_word(pop_word), .pc_load(pc_load), .sp_o(sp_o), .overflow(overflow),
    .underflow(underflow));

  // Synchronous RAM, one-cycle read latency.
  logic [15:0] ram [int];
  always @(posedge clk) begin
    if (mem_we) ram[int'(mem_addr)] = mem_wdata;
    if (mem_re) mem_rdata <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 16'h0;
  end

  // Reference model state.
  int          m_sp;
  logic [15:0] m_stack [int];
  logic        e_pv, e_pcl, e_ovf, e_unf;
  logic [15:0] e_word;

  task automatic check(input logic ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic reset_model();
    m_sp = TOP; e_pv = 0; e_pcl = 0; e_ovf = 0; e_unf = 0; e_word = 0;
  endtask

  // One cycle: drive at the falling edge, check strobes, clock, check results.
  task automatic step(input int op, input logic [15:0] d, input logic [15:0] pc,
                      input logic ld, input logic [15:0] ldv, input string tag);
    logic is_push, is_pop, is_ret, empty, go;
    int   waddr;
    cmd_op = op[2:0]; push_data = d; pc_in = pc; sp_ld_en = ld; sp_ld_val = ldv;
    is_push = !ld && (op == 1 || op == 3 || op == 4);
    is_pop  = !ld && (op == 2 || op == 5 || op == 6);
    is_ret  = !ld && (op == 5 || op == 6);
    empty   = (m_sp >= TOP);
    go      = is_pop && !empty;
    #1;
    check(mem_we === is_push, tag, "mem_we", int'(mem_we), int'(is_push));
    check(mem_re === go, tag, "mem_re", int'(mem_re), int'(go));
    if (is_push) begin
      waddr = (m_sp - 2) & 'hFFFF;
      check(mem_addr === waddr[15:0], tag, "push addr", int'(mem_addr), waddr);
      check(mem_wdata === (op == 1 ? d : pc), tag, "push data", int'(mem_wdata),
            int'(op == 1 ? d : pc));
      m_stack[waddr] = (op == 1) ? d : pc;
    end
    if (go) begin
      check(mem_addr === m_sp[15:0], tag, "pop addr", int'(mem_addr), m_sp);
      e_word = m_stack[m_sp];
    end
    e_pv  = go;
    e_pcl = go && is_ret;
    e_ovf = is_push && (m_sp < FLOOR + 2);
    e_unf = is_pop && empty;
    if (ld)           m_sp = int'(ldv) & 'hFFFE;
    else if (is_push) m_sp = (m_sp - 2) & 'hFFFF;
    else if (go)      m_sp = m_sp + 2;
    @(posedge clk);
    @(negedge clk);
    check(sp_o === m_sp[15:0], tag, "sp", int'(sp_o), m_sp);
    check(sp_o[0] === 1'b0, "R1", "sp bit0", int'(sp_o[0]), 0);
    check(pop_valid === e_pv, tag, "pop_valid", int'(pop_valid), int'(e_pv));
    check(pc_load === e_pcl, tag, "pc_load", int'(pc_load), int'(e_pcl));
    check(overflow === e_ovf, tag, "overflow", int'(overflow), int'(e_ovf));
    check(underflow === e_unf, tag, "underflow", int'(underflow), int'(e_unf));
    if (e_pv) check(pop_word === e_word, tag, "pop_word", int'(pop_word), int'(e_word));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_op = 0; push_data = 0; pc_in = 0; sp_ld_en = 0; sp_ld_val = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    reset_model();
    check(sp_o === 16'(TOP), "R8", "reset sp", int'(sp_o), TOP);
    check(!pop_valid && !pc_load && !overflow && !underflow, "R8", "reset flags",
          int'({pop_valid, pc_load, overflow, underflow}), 0);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R6: pop and return on an empty stack
    step(2, 0, 0, 0, 0, "R6");
    step(5, 0, 0, 0, 0, "R6");
    // R2, R4: pushes and program-counter saves
    step(1, 16'hA1A1, 0, 0, 0, "R2");
    step(1, 16'hB2B2, 0, 0, 0, "R2");
    step(3, 16'hFFFF, 16'h1234, 0, 0, "R4");
    step(4, 16'hFFFF, 16'h5678, 0, 0, "R4");
    // R5, R3: restores and pops in reverse order
    step(6, 0, 0, 0, 0, "R5");
    step(5, 0, 0, 0, 0, "R5");
    step(2, 0, 0, 0, 0, "R3");
    step(2, 0, 0, 0, 0, "R3");
    step(2, 0, 0, 0, 0, "R6");
    // R10: back-to-back mix and idle codes
    for (int i = 0; i < 6; i++) begin
      step(1, 16'(16'h0100 + i), 0, 0, 0, "R10");
      step((i % 2) ? 0 : 7, 0, 0, 0, 0, "R10");
      step(2, 0, 0, 0, 0, "R10");
      step(1, 16'(16'h0200 + i), 0, 0, 0, "R10");
    end
    // R7: fill past the floor
    for (int i = 0; i < 20; i++) step(1, 16'(16'hC000 + i), 0, 0, 0, "R7");
    for (int i = 0; i < 4; i++) step(2, 0, 0, 0, 0, "R7");
    // R1: direct loads with odd values
    step(0, 0, 0, 1, 16'h0271, "R1");
    step(1, 16'hD00D, 0, 0, 0, "R1");
    step(2, 0, 0, 0, 0, "R1");
    // R9: load collides with commands
    step(1, 16'hEEEE, 0, 1, 16'h0265, "R9");
    step(5, 0, 0, 1, 16'h0279, "R9");
    step(4, 0, 16'h4444, 1, 16'h0270, "R9");
    // R6: pointer above the empty value
    step(0, 0, 0, 1, 16'h0301, "R1");
    step(2, 0, 0, 0, 0, "R6");
    step(6, 0, 0, 0, 0, "R6");
    // R7: pointer loaded below the floor, then a wrap near zero
    step(0, 0, 0, 1, 16'h0001, "R1");
    step(3, 0, 16'h7777, 0, 0, "R7");
    // R8: reset restores the empty pointer
    do_reset();
    step(1, 16'h9999, 0, 0, 0, "R2");
    step(2, 0, 0, 0, 0, "R3");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule